// File: doc/BRIEF.md
# UART FIFO Service-Request and Status Logic

This block watches the fill levels of a UART's 8-entry transmit FIFO and 12-entry receive FIFO and turns them into service requests. When the transmit side runs low, or the receive side fills up, it raises a DMA request for that direction. In the same cycle the matching level flag appears in a small status word. The flags need no storage: they follow the occupancy counts directly, and software cannot write them.

Four receiver events also reach the block, each as a one-cycle pulse: line idle, break start, break end and receive error. Each pulse sets a sticky bit. The bit holds until software writes a one to its position in the status word. A write of zero to a position leaves that bit alone.

A single registered interrupt output combines all sources. Each level flag is gated by its own enable input. A sticky bit requests the interrupt for as long as it is set.

Top module: `uart_svc_status`

## Requirements
- R1: Status bit 0 (transmit service) is 1 when the transmit count is 4 or less and 0 when it is 5 or more. Counts above the depth of 8 read as full, so the bit is 0.
- R2: Status bit 1 (receive service) is 1 when the receive count is 8 or more and 0 when it is 7 or less. Counts above the depth of 12 read as full, so the bit is 1.
- R3: `tx_dma_req_o` equals status bit 0 and `rx_dma_req_o` equals status bit 1 in the same cycle, whatever the enable inputs are.
- R4: A write of any value to bits 1:0 of the status word leaves those two bits unchanged.
- R5: A pulse on `rx_idle_i`, `brk_begin_i`, `brk_end_i` or `rx_err_i` sets status bit 2, 3, 4 or 5 respectively from the next clock edge. The bit then stays set until it is cleared.
- R6: A write with a one at bit position 2 to 5 clears that sticky bit from the next edge. A zero at a position leaves that bit unchanged.
- R7: When a set pulse and a write-one clear reach the same sticky bit in the same cycle, the bit ends up set.
- R8: `irq_o` is registered. After each edge it equals the OR, taken in the cycle before that edge, of: (bit 0 AND `tx_ie_i`), (bit 1 AND `rx_ie_i`), and bits 5:2.
- R9: Status bits 7:6 always read 0.
- R10: While `rst_n` is low at a clock edge, all sticky bits and `irq_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count_i | input | 4 | Transmit FIFO occupancy |
| rx_count_i | input | 4 | Receive FIFO occupancy |
| rx_idle_i | input | 1 | Receiver idle event pulse |
| brk_begin_i | input | 1 | Break start event pulse |
| brk_end_i | input | 1 | Break end event pulse |
| rx_err_i | input | 1 | Receive FIFO error event pulse |
| tx_ie_i | input | 1 | Transmit service interrupt enable |
| rx_ie_i | input | 1 | Receive service interrupt enable |
| csr_wr_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | 8 | Write data; ones clear sticky bits |
| csr_status_o | output | 8 | Status word |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Two functions can act on one sticky bit in the same cycle: the hardware set pulse and the software write-one clear. The bench forces this collision on purpose for every sticky bit and checks that the bit remains set after the edge. It then checks that a clear written in the following cycle, with no pulse, does remove the bit. Randomised cycles create further collisions, and a behavioural model compares the status word, both DMA requests and the interrupt against the design on every clock.

// File: rtl/uart_svc_status.sv
module uart_svc_status #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int TX_LOW   = 4,
  parameter int RX_HIGH  = 8,
  parameter int CNT_W    = 4,
  parameter int STAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_idle_i,
  input  logic              brk_begin_i,
  input  logic              brk_end_i,
  input  logic              rx_err_i,
  input  logic              tx_ie_i,
  input  logic              rx_ie_i,
  input  logic              csr_wr_i,
  input  logic [STAT_W-1:0] csr_wdata_i,
  output logic [STAT_W-1:0] csr_status_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic              irq_o
);
  localparam int NSTICKY = 4;
  localparam int SBASE   = 2;
  localparam int CW      = CNT_W + 1;

  logic [CW-1:0] tx_lvl, rx_lvl;
  logic          tx_flag, rx_flag;
  logic [NSTICKY-1:0] evt, sticky, wclr;
  logic          irq_d;

  assign tx_lvl  = ({1'b0, tx_count_i} > CW'(TX_DEPTH)) ? CW'(TX_DEPTH) : {1'b0, tx_count_i};
  assign rx_lvl  = ({1'b0, rx_count_i} > CW'(RX_DEPTH)) ? CW'(RX_DEPTH) : {1'b0, rx_count_i};
  assign tx_flag = tx_lvl <= CW'(TX_LOW);
  assign rx_flag = rx_lvl >= CW'(RX_HIGH);

  assign tx_dma_req_o = tx_flag;
  assign rx_dma_req_o = rx_flag;

  assign evt  = {rx_err_i, brk_end_i, brk_begin_i, rx_idle_i};
  assign wclr = csr_wr_i ? csr_wdata_i[SBASE +: NSTICKY] : '0;

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n)      sticky[i] <= 1'b0;
      else if (evt[i]) sticky[i] <= 1'b1;
      else if (wclr[i]) sticky[i] <= 1'b0;
    end

    // R5: a set bit holds unless written with a one
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_status_o[SBASE+i] && !(csr_wr_i && csr_wdata_i[SBASE+i])) |=> csr_status_o[SBASE+i]);
    // R6: write-one without a pulse clears
    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_i && csr_wdata_i[SBASE+i] && !evt[i]) |=> !csr_status_o[SBASE+i]);
    // R7: set wins over clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && csr_wr_i && csr_wdata_i[SBASE+i]) |=> csr_status_o[SBASE+i]);
  end

  assign irq_d = (tx_flag & tx_ie_i) | (rx_flag & rx_ie_i) | (|sticky);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end

  always_comb begin
    csr_status_o = '0;
    csr_status_o[0] = tx_flag;
    csr_status_o[1] = rx_flag;
    csr_status_o[SBASE +: NSTICKY] = sticky;
  end

  // R3: DMA requests ignore the interrupt enables
  p_tx_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count_i <= CNT_W'(TX_LOW)) |-> tx_dma_req_o);
  p_rx_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count_i >= CNT_W'(RX_HIGH)) |-> rx_dma_req_o);
  // R8: quiet status gives a quiet interrupt one cycle later
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_status_o[SBASE +: NSTICKY] == '0 && !(tx_dma_req_o && tx_ie_i) && !(rx_dma_req_o && rx_ie_i))
    |=> !irq_o);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_status_o[SBASE +: NSTICKY] != '0) |=> irq_o);
  // R9: unused upper bits
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_status_o[STAT_W-1:SBASE+NSTICKY] == '0);
endmodule

// File: tb/uart_svc_status_tb_top.sv
`timescale 1ns/1ps
module uart_svc_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] tx_count = 0, rx_count = 0;
  logic rx_idle = 0, brk_begin = 0, brk_end = 0, rx_err = 0;
  logic tx_ie = 0, rx_ie = 0, csr_wr = 0;
  logic [7:0] csr_wdata = 0;
  logic [7:0] status;
  logic tx_dma, rx_dma, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_svc_status dut_i (
    .clk(clk), .rst_n(rst_n), .tx_count_i(tx_count), .rx_count_i(rx_count),
    .rx_idle_i(rx_idle), .brk_begin_i(brk_begin), .brk_end_i(brk_end), .rx_err_i(rx_err),
    .tx_ie_i(tx_ie), .rx_ie_i(rx_ie), .csr_wr_i(csr_wr), .csr_wdata_i(csr_wdata),
    .csr_status_o(status), .tx_dma_req_o(tx_dma), .rx_dma_req_o(rx_dma), .irq_o(irq));

  // behavioural reference
  bit m_sticky[4];
  bit m_irq;
  function automatic bit m_txf(int c); return c <= 4; endfunction
  function automatic bit m_rxf(int c); return (c > 12 ? 12 : c) >= 8; endfunction

  always @(posedge clk) begin
    bit ev[4];
    bit any;
    ev = '{rx_idle, brk_begin, brk_end, rx_err};
    if (!rst_n) begin
      foreach (m_sticky[i]) m_sticky[i] = 0;
      m_irq = 0;
    end else begin
      any = 0;
      foreach (m_sticky[i]) any |= m_sticky[i];
      m_irq = (m_txf(tx_count) && tx_ie) || (m_rxf(rx_count) && rx_ie) || any;
      foreach (m_sticky[i])
        if (ev[i]) m_sticky[i] = 1;
        else if (csr_wr && csr_wdata[i+2]) m_sticky[i] = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R1 tx flag", status[0], m_txf(tx_count));
      chk("R2 rx flag", status[1], m_rxf(rx_count));
      chk("R3 dma", {tx_dma, rx_dma}, {m_txf(tx_count), m_rxf(rx_count)});
      chk("R5 sticky", status[5:2], {m_sticky[3], m_sticky[2], m_sticky[1], m_sticky[0]});
      chk("R8 irq", irq, m_irq);
      chk("R9 upper", status[7:6], 0);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1.2; end
  endtask

  task automatic quiet();
    {rx_idle, brk_begin, brk_end, rx_err, csr_wr} = 0; csr_wdata = 0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tx_count = 8; rx_count = 0;
    cyc(3);
    chk("R10 reset sticky/irq", {status[5:2], irq}, 0);
    rst_n = 1;
    // R1 sweep
    for (int c = 0; c < 16; c++) begin
      tx_count = c[3:0]; cyc();
      chk("R1 tx sweep", status[0], (c <= 4));
    end
    // R2 sweep
    for (int c = 0; c < 16; c++) begin
      rx_count = c[3:0]; cyc();
      chk("R2 rx sweep", status[1], (c >= 8));
    end
    // R3 with enables off, flags up
    tx_count = 2; rx_count = 10; tx_ie = 0; rx_ie = 0; cyc(2);
    chk("R3 dma ignores enables", {tx_dma, rx_dma}, 2'b11);
    chk("R8 masked irq", irq, 0);
    tx_ie = 1; cyc(); chk("R8 tx enabled irq", irq, 1);
    tx_ie = 0; rx_ie = 1; cyc(); chk("R8 rx enabled irq", irq, 1);
    rx_ie = 0; cyc(); chk("R8 irq drops", irq, 0);
    // R4 writes to flags
    csr_wr = 1; csr_wdata = 8'h03; cyc(); quiet();
    chk("R4 flags unwritten", status[1:0], 2'b11);
    tx_count = 7; rx_count = 3; csr_wr = 1; csr_wdata = 8'hC3; cyc(); quiet();
    chk("R4 flags unwritten low", status[1:0], 2'b00);
    // R5/R6/R7 per sticky bit
    for (int b = 0; b < 4; b++) begin
      {rx_err, brk_end, brk_begin, rx_idle} = 4'(1 << b); cyc(); quiet();
      chk("R5 set", status[b+2], 1);
      chk("R8 sticky irq pending", irq, 0);
      cyc(3); chk("R5 hold", status[b+2], 1); chk("R8 sticky irq", irq, 1);
      csr_wr = 1; csr_wdata = ~8'(1 << (b+2)); cyc(); quiet();
      chk("R6 zero keeps", status[b+2], 1);
      csr_wr = 1; csr_wdata = 8'(1 << (b+2));
      {rx_err, brk_end, brk_begin, rx_idle} = 4'(1 << b); cyc(); quiet();
      chk("R7 set beats clear", status[b+2], 1);
      csr_wr = 1; csr_wdata = 8'(1 << (b+2)); cyc(); quiet();
      chk("R6 one clears", status[b+2], 0);
      cyc(); chk("R8 irq after clear", irq, 0);
    end
    // random phase
    for (int k = 0; k < 3000; k++) begin
      tx_count = 4'($urandom); rx_count = 4'($urandom);
      {rx_idle, brk_begin, brk_end, rx_err} = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      tx_ie = 1'($urandom); rx_ie = 1'($urandom);
      csr_wr = 1'($urandom); csr_wdata = 8'($urandom);
      if (k == 1500) rst_n = 0;
      if (k == 1503) rst_n = 1;
      cyc();
      if (k == 1502) chk("R10 mid reset", {status[5:2], irq}, 0);
    end
    quiet(); cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule